// File: doc/BRIEF.md
# Fuse Array Read Controller

This block lets software fetch one 16-bit word at a time from a one-time-programmable fuse array through a small register bus. Software raises the external enable and waits until the status shows the controller idle. It then writes a 5-bit block index and issues a read command. The controller holds the array request for a programmable number of cycles. On the final cycle it captures the array word into a read-data register and raises a done flag. That flag stays set until software removes it with a separate command.

The register bus has an address, a write strobe, write data and read data. Reads are combinational on the address and carry no handshake. The array side is a plain request port: a request strobe and an index go out, and a 16-bit word comes back. The array must present the word by the last cycle of the read window. The window length comes from the read-timing register. The port has no valid/ready pair, because the window length, rather than back-pressure, sets when the data is taken. Dropping the enable abandons any read in progress. Burning fuses is not part of this block.

Top module: `fuse_rd_ctrl`

## Requirements
- R1: After reset, the status register reads 0x4 while the enable is high and no read has run. Read data reads 0, block index reads 0 and read timing reads 4.
- R2: Byte offsets are decoded as follows: 0x04 read data, 0x0C block index, 0x10 command, 0x14 status, 0x24 read timing. Block index keeps only bits [4:0] and read timing only bits [7:0]. Writes to any other offset are ignored, and reads of any other offset return 0.
- R3: Status bit 1 is read-busy. Bit 2 is standby, which equals enable high and not busy. Bit 3 follows the protect input. Bit 4 is read-done. Bit 0 (program-busy) and bits [31:5] read 0.
- R4: Writing 1 to command bit 1 while standby is set starts a read on the next clock edge and captures the block index. For the whole read, the request output is high and the array index output equals the captured index. The command register always reads 0.
- R5: A read keeps busy high for exactly max(1, T) cycles, where T is the read-timing value.
- R6: The edge that ends a read drops busy, sets done, and loads the read-data register with the array word zero-extended to 32 bits.
- R7: Done stays set until a write of 1 to command bit 2 or an accepted start. A clear that lands on the same edge that ends a read leaves done set.
- R8: A start is ignored while busy or while the enable is low. Rewriting the block index during a read does not change the word fetched.
- R9: Enable low clears busy and done and holds standby low until the enable returns.
- R10: The read-data register changes only when a read completes. An aborted read leaves it unchanged.
- R11: The protect input has no effect on reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mod_en | input | 1 | External module enable |
| prot_in | input | 1 | Protect level, reported in status |
| reg_addr | input | 6 | Register byte offset |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational on address |
| fuse_rd_en | output | 1 | Array read request, high while a read runs |
| fuse_idx | output | 5 | Block index presented to the array |
| fuse_word | input | 16 | Word returned by the array |

## Verification
Two functions can meet on one clock edge: the end of a read, which sets done, and a software clear of done. The bench times a clear write to be sampled on exactly the completing edge and expects done to stay set. It also times a clear one edge earlier, during the read, and expects done to be set afterwards. A further clear one edge later must drop done. A start and a clear written together while idle are also provoked, and the start must win.

// File: rtl/fuse_rd_pkg.sv
package fuse_rd_pkg;
  localparam int unsigned OFF_RDATA = 'h04;
  localparam int unsigned OFF_INDEX = 'h0C;
  localparam int unsigned OFF_CMD   = 'h10;
  localparam int unsigned OFF_STAT  = 'h14;
  localparam int unsigned OFF_RTIME = 'h24;

  localparam int unsigned CMD_START = 1;
  localparam int unsigned CMD_CLEAR = 2;

  // field order gives status bit positions 4..0
  typedef struct packed {
    logic done;
    logic prot;
    logic stby;
    logic busy;
    logic pgm;
  } stat_t;
endpackage

// File: rtl/fuse_rd_regs.sv
module fuse_rd_regs
  import fuse_rd_pkg::*;
#(
  parameter int unsigned ADDR_W   = 6,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned IDX_W    = 5,
  parameter int unsigned TIME_W   = 8,
  parameter int unsigned WORD_W   = 16,
  parameter int unsigned TIME_RST = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  input  stat_t             stat,
  input  logic [WORD_W-1:0] rd_word,
  output logic [DATA_W-1:0] rdata,
  output logic [IDX_W-1:0]  idx_q,
  output logic [TIME_W-1:0] time_q,
  output logic              start_p,
  output logic              clr_p
);
  localparam int unsigned STAT_W = $bits(stat_t);

  logic wr_index, wr_time, wr_cmd;
  logic unused_wbits;

  assign wr_index = we && (addr == ADDR_W'(OFF_INDEX));
  assign wr_time  = we && (addr == ADDR_W'(OFF_RTIME));
  assign wr_cmd   = we && (addr == ADDR_W'(OFF_CMD));

  assign start_p = wr_cmd && wdata[CMD_START];
  assign clr_p   = wr_cmd && wdata[CMD_CLEAR];

  assign unused_wbits = ^{wdata[DATA_W-1:TIME_W], wdata[0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      time_q <= TIME_W'(TIME_RST);
    end else begin
      if (wr_index) idx_q  <= wdata[IDX_W-1:0];
      if (wr_time)  time_q <= wdata[TIME_W-1:0];
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      ADDR_W'(OFF_RDATA): rdata = {{(DATA_W-WORD_W){1'b0}}, rd_word};
      ADDR_W'(OFF_INDEX): rdata = {{(DATA_W-IDX_W){1'b0}}, idx_q};
      ADDR_W'(OFF_STAT):  rdata = {{(DATA_W-STAT_W){1'b0}}, stat};
      ADDR_W'(OFF_RTIME): rdata = {{(DATA_W-TIME_W){1'b0}}, time_q};
      default:            rdata = '0;
    endcase
  end
endmodule

// File: rtl/fuse_rd_seq.sv
module fuse_rd_seq #(
  parameter int unsigned IDX_W  = 5,
  parameter int unsigned TIME_W = 8,
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mod_en,
  input  logic              start_p,
  input  logic              clr_p,
  input  logic [IDX_W-1:0]  idx_q,
  input  logic [TIME_W-1:0] time_q,
  input  logic [WORD_W-1:0] fuse_word,
  output logic              busy,
  output logic              done,
  output logic              standby,
  output logic [WORD_W-1:0] data_q,
  output logic              fuse_rd_en,
  output logic [IDX_W-1:0]  fuse_idx
);
  logic [TIME_W-1:0] cnt;
  logic [TIME_W-1:0] first_cnt;
  logic [IDX_W-1:0]  idx_lat;
  logic              last;

  assign first_cnt  = (time_q == '0) ? '0 : time_q - 1'b1;
  assign last       = busy && (cnt == '0);
  assign standby    = mod_en && !busy;
  assign fuse_rd_en = busy;
  assign fuse_idx   = idx_lat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      cnt     <= '0;
      data_q  <= '0;
      idx_lat <= '0;
    end else if (!mod_en) begin
      busy <= 1'b0;
      done <= 1'b0;
      cnt  <= '0;
    end else if (busy) begin
      if (last) begin
        busy   <= 1'b0;
        done   <= 1'b1;
        data_q <= fuse_word;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end else if (start_p) begin
      busy    <= 1'b1;
      done    <= 1'b0;
      cnt     <= first_cnt;
      idx_lat <= idx_q;
    end else if (clr_p) begin
      done <= 1'b0;
    end
  end

  // R6
  done_on_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (last && mod_en) |=> (!busy && done && data_q == $past(fuse_word)));

  // R7
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && mod_en && !clr_p && !start_p) |=> done);

  // R9
  abort_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mod_en |=> (!busy && !done));

  // R10
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(last && mod_en) |=> $stable(data_q));

  // R8
  idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(fuse_idx));
endmodule

// File: rtl/fuse_rd_ctrl.sv
module fuse_rd_ctrl
  import fuse_rd_pkg::*;
#(
  parameter int unsigned ADDR_W   = 6,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned IDX_W    = 5,
  parameter int unsigned TIME_W   = 8,
  parameter int unsigned WORD_W   = 16,
  parameter int unsigned TIME_RST = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mod_en,
  input  logic              prot_in,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              fuse_rd_en,
  output logic [IDX_W-1:0]  fuse_idx,
  input  logic [WORD_W-1:0] fuse_word
);
  logic [IDX_W-1:0]  idx_q;
  logic [TIME_W-1:0] time_q;
  logic              start_p, clr_p;
  logic              busy, done, standby;
  logic [WORD_W-1:0] data_q;
  stat_t             stat;

  assign stat = '{done: done, prot: prot_in, stby: standby, busy: busy, pgm: 1'b0};

  fuse_rd_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W),
    .TIME_W(TIME_W), .WORD_W(WORD_W), .TIME_RST(TIME_RST)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(reg_addr), .we(reg_we),
    .wdata(reg_wdata), .stat(stat), .rd_word(data_q), .rdata(reg_rdata),
    .idx_q(idx_q), .time_q(time_q), .start_p(start_p), .clr_p(clr_p)
  );

  fuse_rd_seq #(
    .IDX_W(IDX_W), .TIME_W(TIME_W), .WORD_W(WORD_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .mod_en(mod_en), .start_p(start_p),
    .clr_p(clr_p), .idx_q(idx_q), .time_q(time_q), .fuse_word(fuse_word),
    .busy(busy), .done(done), .standby(standby), .data_q(data_q),
    .fuse_rd_en(fuse_rd_en), .fuse_idx(fuse_idx)
  );

  // R3
  stby_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(fuse_rd_en && standby));

  // R4
  start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_p && standby) |=> (fuse_rd_en && fuse_idx == $past(idx_q)));
endmodule

// File: tb/test_fuse_rd_ctrl.sv
module test_fuse_rd_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mod_en = 1'b1;
  logic        prot_in = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        fuse_rd_en;
  logic [4:0]  fuse_idx;
  logic [15:0] fuse_word;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  function automatic logic [15:0] fmodel(input logic [4:0] i);
    return {i, 3'b101, ~i, 3'b010};
  endfunction

  assign fuse_word = fmodel(fuse_idx);

  fuse_rd_ctrl i_fuse_rd_ctrl (
    .clk(clk), .rst_n(rst_n), .mod_en(mod_en), .prot_in(prot_in),
    .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .fuse_rd_en(fuse_rd_en), .fuse_idx(fuse_idx),
    .fuse_word(fuse_word)
  );

  localparam logic [5:0] A_RD = 6'h04, A_IX = 6'h0C, A_CMD = 6'h10,
                         A_ST = 6'h14, A_TM = 6'h24;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] v);
    reg_addr = a;
    #1;
    v = reg_rdata;
  endtask

  task automatic finish_run;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // full read: start, measure busy length, check data, then clear
  task automatic do_read(input logic [4:0] idx, input logic [7:0] t);
    logic [31:0] v;
    int n;
    int eff;
    eff = (t == 0) ? 1 : t;
    wr(A_TM, {24'h0, t});
    wr(A_IX, {27'h0, idx});
    wr(A_CMD, 32'h2);
    check("R4 request and index during read", {26'h0, fuse_rd_en, fuse_idx}, {26'h0, 1'b1, idx});
    n = 0;
    rd(A_ST, v);
    while (v[1]) begin
      n++;
      @(negedge clk);
      rd(A_ST, v);
    end
    check("R5 busy length", n, eff);
    check("R6 done set, standby back", v, 32'h14 | {28'h0, prot_in, 3'b0});
    rd(A_RD, v);
    check("R6 read data word", v, {16'h0, fmodel(idx)});
    wr(A_CMD, 32'h4);
    rd(A_ST, v);
    check("R7 clear drops done", v & 32'h10, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    logic [15:0] prev;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(A_ST, v); check("R1 status after reset", v, 32'h4);
    rd(A_RD, v); check("R1 read data after reset", v, 32'h0);
    rd(A_IX, v); check("R1 index after reset", v, 32'h0);
    rd(A_TM, v); check("R1 timing after reset", v, 32'h4);

    // R2 decode and field widths
    wr(A_IX, 32'hFFFF_FFFF); rd(A_IX, v); check("R2 index width", v, 32'h1F);
    wr(A_TM, 32'h0000_01FF); rd(A_TM, v); check("R2 timing width", v, 32'hFF);
    rd(A_CMD, v); check("R4 command reads zero", v, 32'h0);
    for (int k = 0; k < 4; k++) begin
      logic [5:0] a;
      a = (k == 0) ? 6'h00 : (k == 1) ? 6'h08 : (k == 2) ? 6'h20 : 6'h28;
      wr(a, 32'hFFFF_FFFF);
      rd(a, v); check("R2 unmapped offset reads zero", v, 32'h0);
    end
    rd(A_ST, v); check("R2 unmapped writes start nothing", v, 32'h4);

    // R5 R6 sweep over every block with varying timing
    for (int i = 0; i < 32; i++) begin
      logic [7:0] t;
      t = (i % 5 == 4) ? 8'd6 : 8'(i % 5);
      do_read(5'(i), t);
    end
    do_read(5'd17, 8'd255);

    // R7 clear sampled on the completing edge
    wr(A_TM, 32'd3); wr(A_IX, 32'd12); wr(A_CMD, 32'h2);
    @(negedge clk);
    wr(A_CMD, 32'h4);
    rd(A_ST, v); check("R7 clear on completing edge keeps done", v, 32'h14);
    wr(A_CMD, 32'h4);
    rd(A_ST, v); check("R7 later clear drops done", v, 32'h4);
    // R7 clear one edge early, during busy
    wr(A_CMD, 32'h2);
    wr(A_CMD, 32'h4);
    repeat (3) @(negedge clk);
    rd(A_ST, v); check("R7 early clear does not hide done", v, 32'h14);
    // R7 start and clear together while idle: start wins
    wr(A_CMD, 32'h6);
    rd(A_ST, v); check("R7 start with clear starts read", v, 32'h2);
    repeat (4) @(negedge clk);
    wr(A_CMD, 32'h4);

    // R8 start and index rewrite during a read
    wr(A_TM, 32'd8); wr(A_IX, 32'd3); wr(A_CMD, 32'h2);
    wr(A_IX, 32'd9); wr(A_CMD, 32'h2);
    check("R8 array index held during read", {27'h0, fuse_idx}, 32'd3);
    repeat (6) @(negedge clk);
    rd(A_ST, v); check("R8 no restart after read", v, 32'h14);
    rd(A_RD, v); check("R8 word from first index", v, {16'h0, fmodel(5'd3)});
    rd(A_IX, v); check("R8 index register rewritten", v, 32'd9);
    prev = fmodel(5'd3);

    // R9 R10 abort
    wr(A_TM, 32'd20); wr(A_IX, 32'd7); wr(A_CMD, 32'h2);
    repeat (3) @(negedge clk);
    mod_en = 1'b0;
    @(negedge clk);
    rd(A_ST, v); check("R9 abort clears busy, done, standby", v, 32'h0);
    check("R9 request dropped", {31'h0, fuse_rd_en}, 32'h0);
    rd(A_RD, v); check("R10 aborted read keeps data", v, {16'h0, prev});
    wr(A_CMD, 32'h2);
    mod_en = 1'b1;
    #1;
    rd(A_ST, v); check("R8 start while disabled ignored", v, 32'h4);
    repeat (25) @(negedge clk);
    rd(A_RD, v); check("R10 data still held", v, {16'h0, prev});

    // R3 R11 protect input
    prot_in = 1'b1;
    rd(A_ST, v); check("R3 protect bit follows input", v, 32'hC);
    do_read(5'd5, 8'd2);
    prot_in = 1'b0;
    rd(A_ST, v); check("R11 protect released", v, 32'h4);

    finish_run();
  end
endmodule